// File: doc/BRIEF.md
# GPIO Input Deglitch Filter

This block cleans up one general-purpose input pin before the pin's interrupt and status logic see it. The pad level is first brought into the system clock domain by a two-flop synchronizer. It then passes through a filter that is timed by a slow real-time tick. The tick arrives as a one-cycle enable pulse in the system clock domain. A new level is accepted only after it has been held for a programmed time. The synchronized but unfiltered level is also provided, so a direct read of the pad does not have to wait for the filter.

Three static configuration inputs set the filter:

- A two-bit mode selects one of four behaviours: pass-through, filtering of both directions, filtering of rising changes only, or filtering of falling changes only.
- A two-bit scale selects how many real-time ticks make one timer unit.
- A four-bit count gives the number of units to wait.

The configuration is sampled on every clock. Any change to it restarts the accumulated time. The register bus, pad pulls, drive strength and interrupt generation sit elsewhere in the chip.

Top module: `gpio_deglitch`

## Requirements
- R1: While reset is low, at the next clock edge and after it, `pin_raw` and `pin_level` are both 0, whatever `pad_in` does.
- R2: `pin_raw` equals the value that `pad_in` had two clock edges earlier, because it passes through a two-flop synchronizer.
- R3: With `cfg_mode` = 0 (pass-through), `pin_level` takes the value of `pin_raw` at the next clock edge, and `cfg_scale` and `cfg_count` have no effect.
- R4: One timer unit is 2, 8, 512 or 2048 ticks for `cfg_scale` = 0, 1, 2 or 3. The filter time is `cfg_count` units. A tick counts only in a cycle where `pin_raw` differs from `pin_level` in a filtered direction and the configuration equals the value it had in the previous cycle. `pin_level` takes the new level at the clock edge that ends the cycle holding the last counted tick.
- R5: A `cfg_count` of 0 gives the same filter time as a count of 1.
- R6: With `cfg_mode` = 1, both rising and falling changes are filtered. A return of `pin_raw` to the current `pin_level` before the time has run out discards the accumulated ticks, so a shorter pulse never reaches `pin_level`.
- R7: With `cfg_mode` = 2, rising changes are filtered as in R4. A falling change of `pin_raw` reaches `pin_level` at the next clock edge.
- R8: With `cfg_mode` = 3, falling changes are filtered as in R4. A rising change of `pin_raw` reaches `pin_level` at the next clock edge.
- R9: A change of any configuration input discards the ticks already counted. Counting starts again after the cycle in which the change appeared.
- R10: Without real-time ticks, a filtered change never reaches `pin_level`, however long the level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rtc_tick | input | 1 | One-cycle pulse per real-time tick |
| pad_in | input | 1 | Asynchronous pad level |
| cfg_mode | input | 2 | 0 pass-through, 1 both directions, 2 rising only, 3 falling only |
| cfg_scale | input | 2 | Timer unit: 2, 8, 512 or 2048 ticks |
| cfg_count | input | 4 | Filter time in units (0 is treated as 1) |
| pin_raw | output | 1 | Synchronized, unfiltered pad level |
| pin_level | output | 1 | Filtered pin level |

## Verification
A prescaler or timeout counter that is left with a stale value shows up as an accepted edge arriving early or late by a whole number of ticks. The bench measures this from the first cycle of a mismatch to the change of `pin_level`, so an error appears at the end of one filter interval. A wrong direction decision makes an edge that should be immediate take the full filter time, or makes an edge that should be filtered arrive one cycle after `pin_raw`. A cycle-accurate reference model running beside the design detects either error on the first wrong cycle.

// File: rtl/gpio_dbf_pkg.sv
// Package: shared mode encoding and timer-unit lookup for the deglitch filter.
// Assumes the scale field is two bits wide and selects among four power-of-two
// tick multiples.
package gpio_dbf_pkg;

    typedef enum logic [1:0] {
        DBF_BYPASS    = 2'd0,
        DBF_BOTH      = 2'd1,
        DBF_RISE_ONLY = 2'd2,
        DBF_FALL_ONLY = 2'd3
    } dbf_mode_e;

    // Largest log2 of ticks per unit; sizes the prescaler.
    localparam int unsigned UNIT_SHIFT_MAX = 11;

    // Log2 of the number of real-time ticks in one timer unit.
    function automatic int unsigned unit_shift(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return 3;
            2'd2:    return 9;
            default: return 11;
        endcase
    endfunction

    // True when a change towards new_level is subject to the timer.
    function automatic logic dir_filtered(input dbf_mode_e mode, input logic new_level);
        unique case (mode)
            DBF_BYPASS:    return 1'b0;
            DBF_BOTH:      return 1'b1;
            DBF_RISE_ONLY: return new_level;
            default:       return ~new_level;
        endcase
    endfunction

endpackage

// File: rtl/gpio_dbf_sync.sv
// Module: multi-stage synchronizer for the asynchronous pad level.
// Assumes STAGES >= 2. The output is the last stage, so the latency is STAGES
// clocks. Reset clears every stage to 0.
module gpio_dbf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pad level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_dbf_prescale.sv
// Module: divides real-time ticks into timer units.
// unit_pulse is high in a cycle whose tick completes a unit. A clear holds the
// count at zero and suppresses the pulse. The scale select is treated as static
// while counting; the top clears the count when it changes.
module gpio_dbf_prescale
    import gpio_dbf_pkg::*;
#(
    parameter int unsigned PRE_W = UNIT_SHIFT_MAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] scale,
    output logic       unit_pulse
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last_val;
    logic             at_last;

    // Terminal count for the selected unit: 2^shift - 1.
    always_comb begin
        last_val = PRE_W'((32'd1 << unit_shift(scale)) - 32'd1);
        at_last  = (cnt_q == last_val);
    end

    assign unit_pulse = tick & at_last & ~clr;

    // Count ticks within the current unit, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_last ? '0 : cnt_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/gpio_dbf_timeout.sv
// Module: counts whole timer units up to the programmed count.
// expire is high in the cycle whose unit pulse completes the count. A count of
// zero is treated as one unit. A clear, or an expiry, returns the count to zero.
module gpio_dbf_timeout #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             unit_pulse,
    input  logic [CNT_W-1:0] count_cfg,
    output logic             expire
);
    logic [CNT_W-1:0] units_q;
    logic [CNT_W-1:0] last_unit;

    // Index of the last unit; a zero setting behaves like one.
    always_comb begin
        last_unit = (count_cfg == '0) ? '0 : count_cfg - CNT_W'(1);
    end

    assign expire = unit_pulse & ~clr & (units_q == last_unit);

    // Accumulate completed units while a filtered change is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            units_q <= '0;
        end else if (clr || expire) begin
            units_q <= '0;
        end else if (unit_pulse) begin
            units_q <= units_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/gpio_deglitch.sv
// Module: deglitch filter for one GPIO input, timed by a real-time tick.
// Assumes rtc_tick is a single-cycle pulse already in the clk domain, and that
// the configuration is quasi-static. Any change to it restarts the timer.
// pin_level is registered in every mode, including pass-through.
module gpio_deglitch
    import gpio_dbf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick,
    input  logic             pad_in,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_scale,
    input  logic [CNT_W-1:0] cfg_count,
    output logic             pin_raw,
    output logic             pin_level
);
    localparam int unsigned CFG_W = 4 + CNT_W;

    logic             raw_s;
    logic             lvl_q;
    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;
    logic             differ;
    logic             filt_dir;
    logic             pend;
    logic             tmr_clr;
    logic             unit_pulse;
    logic             expire;
    dbf_mode_e        mode;

    gpio_dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (raw_s)
    );

    // Decode the direction of a pending change and when the timer restarts.
    always_comb begin
        mode     = dbf_mode_e'(cfg_mode);
        cfg_now  = {cfg_mode, cfg_scale, cfg_count};
        cfg_chg  = (cfg_now != cfg_q);
        differ   = (raw_s != lvl_q);
        filt_dir = dir_filtered(mode, raw_s);
        pend     = differ & filt_dir;
        tmr_clr  = ~pend | cfg_chg;
    end

    gpio_dbf_prescale #(.PRE_W(UNIT_SHIFT_MAX)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tmr_clr),
        .tick       (rtc_tick),
        .scale      (cfg_scale),
        .unit_pulse (unit_pulse)
    );

    gpio_dbf_timeout #(.CNT_W(CNT_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tmr_clr),
        .unit_pulse (unit_pulse),
        .count_cfg  (cfg_count),
        .expire     (expire)
    );

    // Remember the previous configuration to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_now;
        end
    end

    // Update the filtered level: at once when unfiltered, or when the timer expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if ((differ && !filt_dir) || expire) begin
            lvl_q <= raw_s;
        end
    end

    assign pin_raw   = raw_s;
    assign pin_level = lvl_q;
endmodule

// File: rtl/gpio_deglitch_chk.sv
// Module: temporal checks on the deglitch filter ports, attached to the top
// module by bind. Uses only port-level signals.
module gpio_deglitch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rtc_tick,
    input logic [1:0] cfg_mode,
    input logic       pin_raw,
    input logic       pin_level
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!pin_raw && !pin_level));                              // R1

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0) |=> (pin_level == $past(pin_raw)));             // R3

    AST_RISE_MODE_FALL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && !pin_raw && pin_level) |=> !pin_level);       // R7

    AST_FALL_MODE_RISE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && pin_raw && !pin_level) |=> pin_level);        // R8

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && !rtc_tick) |=> $stable(pin_level));           // R10

    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && !rtc_tick) |=> !$rose(pin_level));            // R10
endmodule

bind gpio_deglitch gpio_deglitch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rtc_tick  (rtc_tick),
    .cfg_mode  (cfg_mode),
    .pin_raw   (pin_raw),
    .pin_level (pin_level)
);

// File: tb/gpio_deglitch_tb_top.sv
// Bench: directed corner cases and seeded random segments. A reference model
// runs in step with the design and is built from the requirements.
module gpio_deglitch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_tick = 1'b0;
    logic       pad = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] scale = 2'd0;
    logic [3:0] count = 4'd0;
    logic       pin_raw;
    logic       pin_level;

    int unsigned checks = 0;
    int unsigned errs = 0;
    int unsigned cyc = 0;
    bit          cmp_on = 1'b0;

    always #5 clk = ~clk;

    gpio_deglitch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rtc_tick  (rtc_tick),
        .pad_in    (pad),
        .cfg_mode  (mode),
        .cfg_scale (scale),
        .cfg_count (count),
        .pin_raw   (pin_raw),
        .pin_level (pin_level)
    );

    function automatic int unsigned unit_ticks(input logic [1:0] s);
        case (s)
            2'd0: return 2;
            2'd1: return 8;
            2'd2: return 512;
            default: return 2048;
        endcase
    endfunction

    function automatic int unsigned limit_ticks(input logic [1:0] s, input logic [3:0] c);
        return ((c == 4'd0) ? 1 : int'(c)) * unit_ticks(s);
    endfunction

    function automatic bit filtered(input logic [1:0] m, input logic to_lvl);
        case (m)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return to_lvl;
            default: return ~to_lvl;
        endcase
    endfunction

    function automatic string req_of_mode(input logic [1:0] m);
        case (m)
            2'd0: return "R3";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Reference model of the filter, built from the requirements.
    logic        m_s1 = 1'b0, m_s2 = 1'b0, m_lvl = 1'b0;
    logic [7:0]  m_cfg_q = 8'd0;
    int unsigned m_ticks = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_lvl <= 1'b0; m_cfg_q <= 8'd0; m_ticks <= 0;
        end else begin
            m_s1    <= pad;
            m_s2    <= m_s1;
            m_cfg_q <= {mode, scale, count};
            if (m_s2 != m_lvl && !filtered(mode, m_s2)) begin
                m_lvl   <= m_s2;
                m_ticks <= 0;
            end else if (m_s2 == m_lvl || {mode, scale, count} != m_cfg_q) begin
                m_ticks <= 0;
            end else if (rtc_tick) begin
                if (m_ticks + 1 >= limit_ticks(scale, count)) begin
                    m_lvl   <= m_s2;
                    m_ticks <= 0;
                end else begin
                    m_ticks <= m_ticks + 1;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge (R2 raw path, per-mode level).
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(pin_raw == m_s2, "R2", int'(pin_raw), int'(m_s2));
            chk(pin_level == m_lvl, req_of_mode(mode), int'(pin_level), int'(m_lvl));
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errs++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errs, checks + 1);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Bring pad and level to v through pass-through, then load a configuration.
    task automatic settle(input logic v, input logic [1:0] m, input logic [1:0] s, input logic [3:0] c);
        pad = v; mode = 2'd0;
        wait_n(5);
        mode = m; scale = s; count = c;
        wait_n(2);
    endtask

    // Count negedges from the first mismatch sample until pin_level reaches to_val.
    task automatic measure(input logic to_val, input int exp_n, input string req);
        int k;
        pad = to_val;
        do @(negedge clk); while (pin_raw != to_val);
        k = 0;
        while (pin_level != to_val && k < 40000) begin
            @(negedge clk);
            k++;
        end
        chk(k == exp_n, req, k, exp_n);
    endtask

    initial begin
        int unsigned seed_v;
        int k;
        seed_v = $urandom(32'h5EED_0C0D);

        // R1: outputs low during reset even with the pad high.
        pad = 1'b1;
        wait_n(3);
        chk(pin_raw == 1'b0, "R1", int'(pin_raw), 0);
        chk(pin_level == 1'b0, "R1", int'(pin_level), 0);
        rst_n = 1'b1;
        pad = 1'b0;
        wait_n(4);
        cmp_on = 1'b1;

        // R2: raw level appears after two edges.
        pad = 1'b1;
        @(negedge clk);
        chk(pin_raw == 1'b0, "R2", int'(pin_raw), 0);
        @(negedge clk);
        chk(pin_raw == 1'b1, "R2", int'(pin_raw), 1);

        // R3: pass-through ignores large timer fields; level follows one edge later.
        settle(1'b0, 2'd0, 2'd3, 4'd15);
        rtc_tick = 1'b0;
        measure(1'b1, 1, "R3");

        // R4: each unit size, mode 1, a tick every cycle.
        rtc_tick = 1'b1;
        settle(1'b0, 2'd1, 2'd0, 4'd3);  measure(1'b1, 6,    "R4");
        settle(1'b0, 2'd1, 2'd1, 4'd3);  measure(1'b1, 24,   "R4");
        settle(1'b0, 2'd1, 2'd2, 4'd3);  measure(1'b1, 1536, "R4");
        settle(1'b0, 2'd1, 2'd3, 4'd15); measure(1'b1, 30720,"R4");
        settle(1'b1, 2'd1, 2'd1, 4'd2);  measure(1'b0, 16,   "R4");

        // R5: a count of zero acts as one unit.
        settle(1'b0, 2'd1, 2'd1, 4'd0);  measure(1'b1, 8, "R5");
        settle(1'b0, 2'd1, 2'd0, 4'd0);  measure(1'b1, 2, "R5");

        // R6: a pulse shorter than the filter time never reaches the level.
        settle(1'b0, 2'd1, 2'd0, 4'd2);
        pad = 1'b1; wait_n(2); pad = 1'b0;
        wait_n(20);
        chk(pin_level == 1'b0, "R6", int'(pin_level), 0);

        // R7: rising filtered, falling immediate.
        settle(1'b0, 2'd2, 2'd1, 4'd5);  measure(1'b1, 40, "R7");
        measure(1'b0, 1, "R7");
        // R8: falling filtered, rising immediate.
        settle(1'b1, 2'd3, 2'd1, 4'd5);  measure(1'b0, 40, "R8");
        measure(1'b1, 1, "R8");

        // R9: a configuration change discards ticks already counted.
        settle(1'b0, 2'd1, 2'd0, 4'd4);
        pad = 1'b1;
        do @(negedge clk); while (pin_raw != 1'b1);
        wait_n(4);
        count = 4'd5;
        wait_n(5);
        chk(pin_level == 1'b0, "R9", int'(pin_level), 0);
        k = 5;
        while (pin_level != 1'b1 && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(k == 11, "R9", k, 11);

        // R10: without ticks, a held filtered level never passes.
        settle(1'b0, 2'd1, 2'd0, 4'd1);
        rtc_tick = 1'b0;
        pad = 1'b1;
        wait_n(200);
        chk(pin_level == 1'b0, "R10", int'(pin_level), 0);
        rtc_tick = 1'b1;
        wait_n(4);
        chk(pin_level == 1'b1, "R10", int'(pin_level), 1);

        // Random segments checked cycle by cycle against the model.
        for (int seg = 0; seg < 24; seg++) begin
            int hold;
            mode  = 2'($urandom % 4);
            scale = 2'($urandom % 2);
            count = 4'($urandom % 16);
            hold  = 1;
            for (int c = 0; c < 1500; c++) begin
                @(negedge clk);
                rtc_tick = (($urandom % 4) != 0);
                hold--;
                if (hold <= 0) begin
                    pad  = ~pad;
                    hold = 1 + int'($urandom % 60);
                end
                if (($urandom % 300) == 0) count = 4'($urandom % 16);
            end
        end

        wait_n(3);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule